// File: doc/BRIEF.md
# Dual-Speed Single-Wire Bus Bit Master

This block drives one open-drain, half-duplex single-wire bus at the bit level. A host picks a command and a speed grade, then pulses `start`. The block then produces one bus slot. A slot is a reset with a presence check, a write of a zero or a one, or a read of one bit. Each speed grade has its own low times, sample points and slot lengths. A recovery interval follows every slot. The recovery interval counts only while the line is seen high, so that a slave still holding the line low delays the next slot.

All bus timing is counted in whole microseconds. The microsecond tick comes from a prescaler whose divide ratio is set by the clock-frequency parameter. The prescaler restarts whenever a slot is accepted, so every slot edge falls an exact number of clocks after the accept edge. The line input passes through a synchronizer before the engine uses it. The engine latches the command and the speed grade when it accepts a slot.

Top module: `swb_master`

## Requirements
- R1: At standard speed (`speed_od`=0) the block holds `bus_pull_low` high for a fixed low time, starting in the clock cycle right after the accepting edge. The low times are: reset (`cmd`=0) 480 us, write-zero (`cmd`=1) 60 us, write-one (`cmd`=2) 6 us, and read (`cmd`=3) 6 us.
- R2: At overdrive (`speed_od`=1) the same low times are 70 us for reset, 8 us for write-zero, 1 us for write-one and 1 us for read.
- R3: A read samples the synchronized line 15 us (standard) or 2 us (overdrive) after the slot starts. `rd_bit` takes the sampled level: 1 for a high line, 0 for a low line.
- R4: A reset samples the line 70 us (standard) or 9 us (overdrive) after the low pulse ends. `presence` becomes 1 if the line was low at that point, and 0 otherwise.
- R5: A bit slot lasts 70 us (standard) or 10 us (overdrive) from its start. A reset slot lasts 890 us or 110 us. Each slot is then followed by a recovery of 5 us (standard) or 2 us (overdrive).
- R6: Recovery counts only while the synchronized line is high. Any low level restarts the recovery time from zero.
- R7: `busy` is high from the accepting edge until the end of recovery. `done` is high for exactly one clock, in the first cycle with `busy` low.
- R8: A `start` pulse that arrives while `busy` is high has no effect.
- R9: The block latches `speed_od` and `cmd` at acceptance. Changing them during a slot does not change that slot's timing.
- R10: `rd_bit` and `presence` change only at the sample point of their own kind of slot. Write slots leave both unchanged.
- R11: The synchronizer adds two clocks of delay to `bus_line`. A rise of the line during recovery therefore starts the recovery count two clocks later.
- R12: One microsecond equals CLK_HZ/1,000,000 clocks. The prescaler restarts on each accept and on each low level seen during recovery.
- R13: After reset, `bus_pull_low`, `busy`, `done`, `rd_bit` and `presence` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| speed_od | input | 1 | Speed grade: 0 standard, 1 overdrive |
| cmd | input | 2 | Slot kind: 0 reset, 1 write-zero, 2 write-one, 3 read |
| start | input | 1 | Request a slot; accepted only while not busy |
| busy | output | 1 | A slot or its recovery is in progress |
| done | output | 1 | One-clock pulse at the end of recovery |
| rd_bit | output | 1 | Level sampled by the most recent read |
| presence | output | 1 | Presence result of the most recent reset |
| bus_pull_low | output | 1 | Enable for the open-drain driver that pulls the line low |
| bus_line | input | 1 | Raw level of the bus line |

## Verification
Let D be the number of clocks in one microsecond. Counting from the accepting edge, `bus_pull_low` covers exactly low×D cycles, and `busy` falls with `done` rising exactly (slot+recovery)×D cycles later. When a slave holds the line past the end of the slot, that point moves to the slave's release cycle plus two synchronizer clocks plus the recovery time. The bench keeps a cycle counter that restarts on acceptance. It samples on the falling clock edge, so each measured count matches these formulas to the exact cycle. It reads `rd_bit` and `presence` only after `done`, when the sample point has safely passed.

// File: rtl/swb_pkg.sv
package swb_pkg;

   // Slot kinds as they appear on the cmd port
   typedef enum logic [1:0] {
      CMD_RESET = 2'd0,
      CMD_WR0   = 2'd1,
      CMD_WR1   = 2'd2,
      CMD_READ  = 2'd3
   } swb_cmd_t;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SLOT  = 2'd1,
      ST_RECOV = 2'd2
   } swb_state_t;

   // Timing in microseconds, standard / overdrive
   localparam int RST_LOW_STD  = 480;
   localparam int RST_LOW_OD   = 70;
   localparam int RST_SAMP_STD = 70;   // after release
   localparam int RST_SAMP_OD  = 9;    // 8.5 rounded up
   localparam int RST_WAIT_STD = 410;  // after release
   localparam int RST_WAIT_OD  = 40;
   localparam int W0_LOW_STD   = 60;
   localparam int W0_LOW_OD    = 8;
   localparam int W1_LOW_STD   = 6;
   localparam int W1_LOW_OD    = 1;
   localparam int RD_LOW_STD   = 6;
   localparam int RD_LOW_OD    = 1;
   localparam int RD_SAMP_STD  = 15;
   localparam int RD_SAMP_OD   = 2;
   localparam int SLOT_STD     = 70;
   localparam int SLOT_OD      = 10;
   localparam int REC_STD      = 5;
   localparam int REC_OD       = 2;

   localparam int US_MAX = RST_LOW_STD + RST_WAIT_STD;
   localparam int US_W   = $clog2(US_MAX + 1);

   typedef logic [US_W-1:0] us_t;

   typedef struct packed {
      us_t low_us;   // end of master low, from slot start
      us_t samp_us;  // sample point, from slot start (0: none)
      us_t end_us;   // slot end, from slot start
      us_t rec_us;   // recovery length
   } swb_timing_t;

   function automatic swb_timing_t swb_timing(input swb_cmd_t c, input logic od);
      swb_timing_t t;
      t.rec_us = od ? us_t'(REC_OD) : us_t'(REC_STD);
      unique case (c)
         CMD_RESET: begin
            t.low_us  = od ? us_t'(RST_LOW_OD) : us_t'(RST_LOW_STD);
            t.samp_us = od ? us_t'(RST_LOW_OD + RST_SAMP_OD) : us_t'(RST_LOW_STD + RST_SAMP_STD);
            t.end_us  = od ? us_t'(RST_LOW_OD + RST_WAIT_OD) : us_t'(RST_LOW_STD + RST_WAIT_STD);
         end
         CMD_WR0: begin
            t.low_us  = od ? us_t'(W0_LOW_OD) : us_t'(W0_LOW_STD);
            t.samp_us = '0;
            t.end_us  = od ? us_t'(SLOT_OD) : us_t'(SLOT_STD);
         end
         CMD_WR1: begin
            t.low_us  = od ? us_t'(W1_LOW_OD) : us_t'(W1_LOW_STD);
            t.samp_us = '0;
            t.end_us  = od ? us_t'(SLOT_OD) : us_t'(SLOT_STD);
         end
         default: begin
            t.low_us  = od ? us_t'(RD_LOW_OD) : us_t'(RD_LOW_STD);
            t.samp_us = od ? us_t'(RD_SAMP_OD) : us_t'(RD_SAMP_STD);
            t.end_us  = od ? us_t'(SLOT_OD) : us_t'(SLOT_STD);
         end
      endcase
      return t;
   endfunction

endpackage

// File: rtl/swb_prescaler.sv
module swb_prescaler #(
   parameter int DIV = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);

   generate
      if (DIV == 1) begin : g_direct
         // Every clock is one microsecond
         assign tick = 1'b1;
         wire unused_pins = &{1'b0, clk, rst_n, restart};
      end else begin : g_count
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (restart || cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick = (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/swb_line_sync.sv
module swb_line_sync #(
   parameter int   STAGES   = 2,
   parameter logic IDLE_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] sr_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr_q[s] <= IDLE_LVL;
            end else begin
               sr_q[s] <= (s == 0) ? d : sr_q[(s == 0) ? 0 : s - 1];
            end
         end
      end
   endgenerate

   assign q = sr_q[STAGES-1];

endmodule

// File: rtl/swb_slot_engine.sv
module swb_slot_engine
   import swb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       line_hi,
   input  logic       start,
   input  logic [1:0] cmd,
   input  logic       speed_od,
   output logic       restart,
   output logic       busy,
   output logic       done,
   output logic       rd_bit,
   output logic       presence,
   output logic       pull_low
);

   swb_state_t  state_q;
   swb_cmd_t    cmd_q;
   logic        od_q;
   us_t         us_q;
   us_t         us_nxt;
   swb_timing_t tim;
   logic        done_q, rd_q, pres_q, pull_q;

   assign tim    = swb_timing(cmd_q, od_q);
   assign us_nxt = us_q + 1'b1;

   // Prescaler realigns on accept and while recovery sees a low line
   assign restart = (state_q == ST_IDLE  && start) ||
                    (state_q == ST_RECOV && !line_hi);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cmd_q   <= CMD_RESET;
         od_q    <= 1'b0;
         us_q    <= '0;
         done_q  <= 1'b0;
         rd_q    <= 1'b0;
         pres_q  <= 1'b0;
         pull_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_SLOT;
                  cmd_q   <= swb_cmd_t'(cmd);
                  od_q    <= speed_od;
                  us_q    <= '0;
                  pull_q  <= 1'b1;
               end
            end
            ST_SLOT: begin
               if (tick) begin
                  if (us_nxt == tim.low_us) begin
                     pull_q <= 1'b0;
                  end
                  if (us_nxt == tim.samp_us) begin
                     if (cmd_q == CMD_READ) begin
                        rd_q <= line_hi;
                     end
                     if (cmd_q == CMD_RESET) begin
                        pres_q <= ~line_hi;
                     end
                  end
                  if (us_nxt == tim.end_us) begin
                     state_q <= ST_RECOV;
                     us_q    <= '0;
                  end else begin
                     us_q <= us_nxt;
                  end
               end
            end
            ST_RECOV: begin
               if (!line_hi) begin
                  us_q <= '0;
               end else if (tick) begin
                  if (us_nxt == tim.rec_us) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                     us_q    <= '0;
                  end else begin
                     us_q <= us_nxt;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign done     = done_q;
   assign rd_bit   = rd_q;
   assign presence = pres_q;
   assign pull_low = pull_q;

endmodule

// File: rtl/swb_master.sv
module swb_master #(
   parameter int CLK_HZ      = 100_000_000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       speed_od,
   input  logic [1:0] cmd,
   input  logic       start,
   output logic       busy,
   output logic       done,
   output logic       rd_bit,
   output logic       presence,
   output logic       bus_pull_low,
   input  logic       bus_line
);

   localparam int TICKS_PER_US = CLK_HZ / 1_000_000;

   generate
      if (CLK_HZ < 1_000_000 || (CLK_HZ % 1_000_000) != 0) begin : g_bad_clk
         $error("swb_master: CLK_HZ must be a whole multiple of 1 MHz");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("swb_master: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic tick, restart, line_hi;

   swb_prescaler #(
      .DIV (TICKS_PER_US)
   ) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .tick    (tick)
   );

   swb_line_sync #(
      .STAGES   (SYNC_STAGES),
      .IDLE_LVL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (bus_line),
      .q     (line_hi)
   );

   swb_slot_engine u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .line_hi  (line_hi),
      .start    (start),
      .cmd      (cmd),
      .speed_od (speed_od),
      .restart  (restart),
      .busy     (busy),
      .done     (done),
      .rd_bit   (rd_bit),
      .presence (presence),
      .pull_low (bus_pull_low)
   );

endmodule

// File: rtl/swb_master_chk.sv
module swb_master_chk #(
   parameter int CLK_HZ = 100_000_000
) (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic busy,
   input logic done,
   input logic rd_bit,
   input logic presence,
   input logic bus_pull_low
);

   localparam int MAX_LOW = (CLK_HZ / 1_000_000) * swb_pkg::RST_LOW_STD;
   localparam int LW      = $clog2(MAX_LOW + 2);

   logic [LW-1:0] low_run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_run_q <= '0;
      end else if (bus_pull_low) begin
         if (low_run_q != {LW{1'b1}}) low_run_q <= low_run_q + 1'b1;
      end else begin
         low_run_q <= '0;
      end
   end

   // R1: no low pulse longer than the longest reset pulse
   assert_low_bounded_R1: assert property (@(posedge clk) disable iff (!rst_n)
      int'(low_run_q) <= MAX_LOW);

   // R7: the bus is only pulled low during a busy period
   assert_pull_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_pull_low |-> busy);

   // R7: done lasts one clock
   assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: end of busy coincides with done
   assert_busy_fall_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R8: a pull-low pulse begins only after a start seen while idle
   assert_pull_from_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_pull_low) |-> $past(start && !busy));

   // R10: results never move while idle
   assert_results_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> ($stable(rd_bit) && $stable(presence)));

endmodule

bind swb_master swb_master_chk #(
   .CLK_HZ (CLK_HZ)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .busy         (busy),
   .done         (done),
   .rd_bit       (rd_bit),
   .presence     (presence),
   .bus_pull_low (bus_pull_low)
);

// File: tb/swb_master_tb_top.sv
module swb_master_tb_top;

   localparam int CLK_HZ = 4_000_000;
   localparam int D      = CLK_HZ / 1_000_000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       speed_od = 1'b0;
   logic [1:0] cmd = 2'd0;
   logic       start = 1'b0;
   logic       busy, done, rd_bit, presence, bus_pull_low, bus_line;

   int  n_checks = 0;
   int  n_errors = 0;
   int  cyc = 0;
   int  sl_a = 0, sl_b = 0;
   logic sl_en = 1'b0;
   logic sl_low;

   always #5 clk = ~clk;

   swb_master #(.CLK_HZ(CLK_HZ), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .speed_od(speed_od), .cmd(cmd), .start(start),
      .busy(busy), .done(done), .rd_bit(rd_bit), .presence(presence),
      .bus_pull_low(bus_pull_low), .bus_line(bus_line)
   );

   // Cycles since the accepting edge
   always_ff @(posedge clk) begin
      if (start && !busy) cyc <= 0;
      else cyc <= cyc + 1;
   end

   // Slave model: wired-AND with the master
   assign sl_low   = sl_en && (cyc >= sl_a) && (cyc < sl_b);
   assign bus_line = !(bus_pull_low || sl_low);

   function automatic int exp_low(input int c, input bit od);
      case (c)
         0: return od ? 70 : 480;
         1: return od ? 8 : 60;
         default: return od ? 1 : 6;
      endcase
   endfunction

   function automatic int exp_end(input int c, input bit od);
      if (c == 0) return od ? 110 : 890;
      return od ? 10 : 70;
   endfunction

   function automatic int exp_rec(input bit od);
      return od ? 2 : 5;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // kind: 0 none, 1 slave pulls low (presence / read zero), 2 read zero held past slot end
   task automatic run_op(input int c, input bit od, input int kind,
                         input bit inject, input bit toggle);
      int low_cnt = 0, low_first = -1, busy_cnt = 0, done_at = -1, t_exp;
      int prev_rd = int'(rd_bit), prev_pr = int'(presence);
      bit exp_bit;
      sl_en = 1'b0;
      if (kind == 1 && c == 0) begin
         sl_a = (exp_low(0, od) + (od ? 2 : 15)) * D;
         sl_b = (exp_low(0, od) + (od ? 20 : 200)) * D;
         sl_en = 1'b1;
      end else if (kind == 1 && c == 3) begin
         sl_a = 0; sl_b = (od ? 4 : 30) * D; sl_en = 1'b1;
      end else if (kind == 2 && c == 3) begin
         sl_a = 0; sl_b = (exp_end(3, od) + 3) * D; sl_en = 1'b1;
      end
      t_exp = exp_end(c, od) * D;
      if (kind == 2 && c == 3 && sl_b + 2 > t_exp) t_exp = sl_b + 2;
      t_exp += exp_rec(od) * D;

      @(negedge clk);
      start = 1'b1; cmd = 2'(c); speed_od = od;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (i == 0) start = 1'b0;
         if (toggle && i == 10) speed_od = ~od;
         if (inject && i == 20) begin start = 1'b1; cmd = 2'd0; end
         if (inject && i == 21) start = 1'b0;
         if (bus_pull_low) begin
            low_cnt++;
            if (low_first < 0) low_first = cyc;
         end
         if (busy) busy_cnt++;
         if (done) begin done_at = cyc; break; end
      end
      // R1 / R2 / R12: pulse starts at once and spans low*D clocks
      chk(low_first == 0, "R1 pull-low start cycle", low_first, 0);
      chk(low_cnt == exp_low(c, od) * D, od ? "R2 overdrive low width" : "R1 standard low width",
          low_cnt, exp_low(c, od) * D);
      // R5 / R6 / R11 / R8 / R9: slot plus recovery length
      chk(done_at == t_exp, "R5 R6 R11 done cycle", done_at, t_exp);
      chk(busy_cnt == t_exp, "R7 busy length", busy_cnt, t_exp);
      @(negedge clk);
      chk(!done && !busy, "R7 done single pulse", int'(done), 0);
      if (c == 3) begin
         exp_bit = (kind == 0);
         chk(rd_bit == exp_bit, "R3 read value", int'(rd_bit), int'(exp_bit));
      end else if (c == 0) begin
         exp_bit = (kind == 1);
         chk(presence == exp_bit, "R4 presence", int'(presence), int'(exp_bit));
      end else begin
         chk(int'(rd_bit) == prev_rd && int'(presence) == prev_pr, "R10 write keeps results",
             int'({rd_bit, presence}), (prev_rd * 2) + prev_pr);
      end
      sl_en = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (190_000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R13 reset state
      chk(!bus_pull_low && !busy && !done && !rd_bit && !presence, "R13 reset state",
          int'({bus_pull_low, busy, done, rd_bit, presence}), 0);

      // Directed: every kind at both speeds
      run_op(0, 1'b0, 1, 1'b0, 1'b0);
      run_op(0, 1'b1, 0, 1'b0, 1'b0);
      run_op(0, 1'b1, 1, 1'b0, 1'b0);
      run_op(1, 1'b0, 0, 1'b0, 1'b0);
      run_op(1, 1'b1, 0, 1'b0, 1'b0);
      run_op(2, 1'b0, 0, 1'b0, 1'b0);
      run_op(2, 1'b1, 0, 1'b0, 1'b0);
      run_op(3, 1'b0, 1, 1'b0, 1'b0);
      run_op(3, 1'b1, 0, 1'b0, 1'b0);
      run_op(3, 1'b1, 1, 1'b0, 1'b0);
      // R6 R11: slave holds past slot end
      run_op(3, 1'b0, 2, 1'b0, 1'b0);
      run_op(3, 1'b1, 2, 1'b0, 1'b0);
      // R8 start while busy, R9 speed change mid-slot
      run_op(1, 1'b1, 0, 1'b1, 1'b0);
      run_op(3, 1'b0, 1, 1'b1, 1'b1);
      run_op(2, 1'b1, 0, 1'b0, 1'b1);

      // Random mix
      for (int k = 0; k < 30; k++) begin
         int  c    = int'($urandom_range(0, 3));
         bit  od   = bit'($urandom_range(0, 1));
         int  kind = 0;
         if (c == 0 || c == 3) kind = int'($urandom_range(0, 1));
         if (c == 3 && ($urandom_range(0, 3) == 0)) kind = 2;
         if (c == 0 && !od) od = bit'($urandom_range(0, 1));
         run_op(c, od, kind, bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
      end

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule